// File: doc/BRIEF.md
# Multiplexed-Address DRAM Model with Page and Nibble Access

This block is a cycle-based behavioural model of a one-bit-wide dynamic memory laid out as a square array of cells. A single address bus carries both halves of an address. A row strobe marks it as a row number, and a column strobe marks it as a column number. Opening a row copies that whole row into a bank of column latches. Every later column access is served from those latches. When the row closes, the latches are written back into the array.

While a row is open, any number of column strobes may follow (page access). If the nibble input is high at a column strobe, the block runs four accesses on its own from one strobe. The first uses the supplied column. The next three step the two low column bits modulo four. A row strobe given with no column strobe rewrites the row unchanged, which is how refresh is done. Each row has an age counter. A sticky flag records that some row went longer than the retention limit without being opened or closed. A column strobe with no open row is reported as an error.

The array side is set by `ADDR_W`: rows = columns = 2^ADDR_W, and the real part is 11. The retention limit is set by `RET_LIMIT`, which defaults to about a million cycles. A simulation can shrink both.

Top module: `dram_mux_addr`

## Requirements
- R1: After synchronous reset, `dout_vld`, `err` and `ret_err` are 0, no row is open, and every cell reads 0.
- R2: When `ras` is high while no row is open, the clock edge takes `addr` as the row number, opens that row and loads all of its cells into the column latches.
- R3: A rising edge of `cas` (high now, low in the previous cycle) with `ras` high, a row open and `we` low is a read. At that same clock edge, `dout` takes the latched bit at column `addr`, and `dout_vld` is high for the following cycle only.
- R4: The same strobe with `we` high is a write. The latched bit at column `addr` takes `din`, `dout_vld` stays 0, and later reads of that column in the open row return the new value.
- R5: While `ras` stays high, the row stays open and its row number does not change, whatever is on `addr`. Repeated column strobes are each served from the latches.
- R6: If `nib` is high at the column strobe edge, the block makes four accesses on four consecutive clock edges. Their columns are c, then c with bits [1:0] replaced by (c[1:0]+1), (c[1:0]+2) and (c[1:0]+3), each modulo 4. The upper bits of c stay the same. All four beats are reads or all four are writes, as `we` was at the strobe edge, and each write beat takes `din` at its own edge.
- R7: Column strobe edges that arrive while a nibble burst is running are ignored. They cause no extra access and no error.
- R8: When `ras` is low while a row is open, the clock edge writes the latches back into that row and closes it. A burst still running stops with no further beats.
- R9: A row strobe with no column strobe (open, then close) leaves the row's contents unchanged and restarts that row's age.
- R10: A column strobe edge while no row is open, or while `ras` is low, makes `err` high for the next cycle only. It produces no `dout_vld` and changes no cell.
- R11: Every row's age counts clock cycles since that row was last opened or closed. Once any age reaches `RET_LIMIT`, `ret_err` becomes 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Shared row/column address |
| ras | input | 1 | Row strobe, active high; high holds the row open |
| cas | input | 1 | Column strobe, active high; rising edge starts an access |
| we | input | 1 | Write select, sampled at the column strobe edge |
| nib | input | 1 | Nibble burst select, sampled at the column strobe edge |
| din | input | 1 | Write data |
| dout | output | 1 | Read data |
| dout_vld | output | 1 | `dout` carries a fresh read bit this cycle |
| err | output | 1 | Column strobe without an open row |
| ret_err | output | 1 | Sticky retention-limit violation |

## Verification
A single read shows `dout`/`dout_vld` in the cycle after the edge that samples the column strobe. A nibble burst shows its four beats in the four cycles after its first edge. `err` follows the bad strobe by one cycle. The bench drives each input on a falling edge and samples at the next falling edge, exactly one rising edge later. It then samples again one cycle after the last expected beat, to confirm that `dout_vld` has dropped. For retention, the bench checks `ret_err` only after a refresh sweep whose per-row interval is far below the limit, and again after an idle stretch well beyond it. This keeps the check independent of the exact cycle at which the flag rises.

// File: rtl/dram_pkg.sv
package dram_pkg;

    typedef enum logic {
        ROW_IDLE = 1'b0,
        ROW_OPEN = 1'b1
    } row_state_e;

    typedef struct packed {
        logic       active;
        logic       wr;
        logic [1:0] beat;
    } burst_t;

    function automatic logic [1:0] wrap_beat(input logic [1:0] base_lo,
                                             input logic [1:0] beat);
        return base_lo + beat;
    endfunction

    function automatic logic last_beat(input logic [1:0] beat);
        return beat == 2'd3;
    endfunction

endpackage

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
    parameter int AW   = 4,
    parameter int ROWS = 16,
    parameter int COLS = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   rd_row,
    output logic [COLS-1:0] rd_data,
    input  logic            wb_en,
    input  logic [AW-1:0]   wb_row,
    input  logic [COLS-1:0] wb_data
);
    logic [COLS-1:0] cells [ROWS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ROWS; i++) cells[i] <= '0;
        end else if (wb_en) begin
            cells[wb_row] <= wb_data;
        end
    end

    assign rd_data = cells[rd_row];
endmodule

// File: rtl/dram_row_ctrl.sv
module dram_row_ctrl
    import dram_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ras,
    input  logic [AW-1:0] addr,
    output logic          row_open,
    output logic [AW-1:0] row_q,
    output logic          load_en,
    output logic          close_en
);
    row_state_e state_q;

    assign row_open = (state_q == ROW_OPEN);
    assign load_en  = ras && !row_open;
    assign close_en = !ras && row_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ROW_IDLE;
            row_q   <= '0;
        end else if (load_en) begin
            state_q <= ROW_OPEN;
            row_q   <= addr;
        end else if (close_en) begin
            state_q <= ROW_IDLE;
        end
    end
endmodule

// File: rtl/dram_col_unit.sv
module dram_col_unit
    import dram_pkg::*;
#(
    parameter int AW   = 4,
    parameter int COLS = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            row_open,
    input  logic            ras,
    input  logic            cas,
    input  logic            we,
    input  logic            nib,
    input  logic            din,
    input  logic [AW-1:0]   addr,
    input  logic            load_en,
    input  logic [COLS-1:0] load_data,
    output logic [COLS-1:0] latches,
    output logic            dout,
    output logic            dout_vld,
    output logic            err
);
    logic          cas_q;
    burst_t        bst_q;
    logic [AW-1:0] base_q;
    logic          cas_edge, start, bad, beat_go, acc_go, acc_wr;
    logic [AW-1:0] acc_col, burst_col;

    assign cas_edge = cas && !cas_q;
    assign start    = cas_edge && row_open && ras && !bst_q.active;
    assign bad      = cas_edge && !(row_open && ras);
    assign beat_go  = bst_q.active && row_open && ras;
    assign acc_go   = start || beat_go;
    assign acc_wr   = start ? we : bst_q.wr;

    always_comb begin
        burst_col      = base_q;
        burst_col[1:0] = wrap_beat(base_q[1:0], bst_q.beat);
        acc_col        = start ? addr : burst_col;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cas_q    <= 1'b0;
            latches  <= '0;
            dout     <= 1'b0;
            dout_vld <= 1'b0;
            err      <= 1'b0;
        end else begin
            cas_q    <= cas;
            err      <= bad;
            dout_vld <= acc_go && !acc_wr;
            if (acc_go && !acc_wr) dout <= latches[acc_col];
            if (load_en) latches <= load_data;
            else if (acc_go && acc_wr) latches[acc_col] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bst_q  <= '0;
            base_q <= '0;
        end else if (start && nib) begin
            bst_q.active <= 1'b1;
            bst_q.wr     <= we;
            bst_q.beat   <= 2'd1;
            base_q       <= addr;
        end else if (bst_q.active) begin
            if (!beat_go || last_beat(bst_q.beat)) bst_q.active <= 1'b0;
            bst_q.beat <= bst_q.beat + 2'd1;
        end
    end
endmodule

// File: rtl/dram_retention.sv
module dram_retention #(
    parameter int AW        = 4,
    parameter int ROWS      = 16,
    parameter int RET_LIMIT = 1048576
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_en,
    input  logic [AW-1:0] addr,
    input  logic          close_en,
    input  logic [AW-1:0] row_q,
    output logic          ret_err
);
    localparam int AGE_W = $clog2(RET_LIMIT + 1);
    localparam logic [AGE_W-1:0] LIMIT = AGE_W'(RET_LIMIT);

    logic [ROWS-1:0] hit;

    for (genvar r = 0; r < ROWS; r++) begin : g_age
        logic [AGE_W-1:0] age_q;
        logic             touch;
        assign touch = (load_en && addr == AW'(r)) || (close_en && row_q == AW'(r));
        assign hit[r] = (age_q == LIMIT);
        always_ff @(posedge clk) begin
            if (rst || touch)   age_q <= '0;
            else if (!hit[r])   age_q <= age_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ret_err <= 1'b0;
        else     ret_err <= ret_err || (|hit);
    end
endmodule

// File: rtl/dram_mux_addr.sv
module dram_mux_addr
    import dram_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int RET_LIMIT = 1048576
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ras,
    input  logic              cas,
    input  logic              we,
    input  logic              nib,
    input  logic              din,
    output logic              dout,
    output logic              dout_vld,
    output logic              err,
    output logic              ret_err
);
    localparam int ROWS = 1 << ADDR_W;
    localparam int COLS = 1 << ADDR_W;

    logic              row_open, load_en, close_en;
    logic [ADDR_W-1:0] row_q;
    logic [COLS-1:0]   rd_data, latches;

    dram_row_ctrl #(.AW(ADDR_W)) u_row (
        .clk(clk), .rst(rst), .ras(ras), .addr(addr),
        .row_open(row_open), .row_q(row_q),
        .load_en(load_en), .close_en(close_en)
    );

    dram_cell_array #(.AW(ADDR_W), .ROWS(ROWS), .COLS(COLS)) u_array (
        .clk(clk), .rst(rst), .rd_row(addr), .rd_data(rd_data),
        .wb_en(close_en), .wb_row(row_q), .wb_data(latches)
    );

    dram_col_unit #(.AW(ADDR_W), .COLS(COLS)) u_col (
        .clk(clk), .rst(rst), .row_open(row_open), .ras(ras), .cas(cas),
        .we(we), .nib(nib), .din(din), .addr(addr),
        .load_en(load_en), .load_data(rd_data), .latches(latches),
        .dout(dout), .dout_vld(dout_vld), .err(err)
    );

    dram_retention #(.AW(ADDR_W), .ROWS(ROWS), .RET_LIMIT(RET_LIMIT)) u_ret (
        .clk(clk), .rst(rst), .load_en(load_en), .addr(addr),
        .close_en(close_en), .row_q(row_q), .ret_err(ret_err)
    );
endmodule

// File: rtl/dram_mux_addr_chk.sv
module dram_mux_addr_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          ras,
    input logic          cas,
    input logic          row_open,
    input logic [AW-1:0] row_q,
    input logic          dout_vld,
    input logic          err,
    input logic          ret_err
);
    AST_OPEN_ON_RAS: assert property (@(posedge clk) disable iff (rst)
        !row_open && ras |=> row_open);                                  // R2
    AST_VLD_NEEDS_ROW: assert property (@(posedge clk) disable iff (rst)
        dout_vld |-> $past(row_open));                                  // R3
    AST_ROW_HELD: assert property (@(posedge clk) disable iff (rst)
        row_open && ras |=> row_open && $stable(row_q));                 // R5
    AST_CLOSE_ON_RAS_LOW: assert property (@(posedge clk) disable iff (rst)
        row_open && !ras |=> !row_open);                                 // R8
    AST_ERR_NEEDS_CAS: assert property (@(posedge clk) disable iff (rst)
        err |-> $past(cas));                                            // R10
    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(err && dout_vld));                                            // R10
    AST_RET_STICKY: assert property (@(posedge clk) disable iff (rst)
        ret_err |=> ret_err);                                           // R11
endmodule

bind dram_mux_addr dram_mux_addr_chk #(.AW(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .ras(ras), .cas(cas), .row_open(row_open),
    .row_q(row_q), .dout_vld(dout_vld), .err(err), .ret_err(ret_err)
);

// File: tb/test_dram_mux_addr.sv
module test_dram_mux_addr;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int N = 1 << AW;
    localparam int LIMIT = 300;

    localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_NR = 2'd2, OP_NW = 2'd3;
    typedef struct packed {
        logic [1:0]    op;
        logic [AW-1:0] row;
        logic [AW-1:0] col;
        logic [3:0]    data;
    } vec_t;
    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{OP_W,  4'd3,  4'd5,  4'd1},
        '{OP_W,  4'd3,  4'd6,  4'd1},
        '{OP_R,  4'd3,  4'd5,  4'd0},
        '{OP_R,  4'd3,  4'd6,  4'd0},
        '{OP_R,  4'd3,  4'd7,  4'd0},
        '{OP_W,  4'd9,  4'd0,  4'd1},
        '{OP_W,  4'd9,  4'd3,  4'd1},
        '{OP_R,  4'd9,  4'd0,  4'd0},
        '{OP_NR, 4'd3,  4'd6,  4'd0},
        '{OP_NR, 4'd9,  4'd2,  4'd0},
        '{OP_NW, 4'd12, 4'd13, 4'b1011},
        '{OP_NR, 4'd12, 4'd12, 4'd0},
        '{OP_W,  4'd3,  4'd5,  4'd0},
        '{OP_R,  4'd3,  4'd5,  4'd0}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic ras = 1'b0, cas = 1'b0, we = 1'b0, nib = 1'b0, din = 1'b0;
    logic dout, dout_vld, err, ret_err;

    int vectors = 0, fails = 0;
    bit done = 1'b0;
    logic [N-1:0] mdl [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_mux_addr #(.ADDR_W(AW), .RET_LIMIT(LIMIT)) i_dram_mux_addr (
        .clk(clk), .rst(rst), .addr(addr), .ras(ras), .cas(cas), .we(we),
        .nib(nib), .din(din), .dout(dout), .dout_vld(dout_vld),
        .err(err), .ret_err(ret_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [AW-1:0] nib_col(input logic [AW-1:0] c, input int b);
        logic [AW-1:0] r;
        r = c;
        r[1:0] = c[1:0] + 2'(b);
        return r;
    endfunction

    task automatic do_reset();
        rst = 1'b1; ras = 0; cas = 0; we = 0; nib = 0; din = 0;
        for (int r = 0; r < N; r++) mdl[r] = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic open_row(input logic [AW-1:0] r);
        ras = 1'b1; addr = r;
        @(negedge clk);
    endtask

    task automatic close_row();
        ras = 1'b0; cas = 1'b0; we = 1'b0; nib = 1'b0;
        @(negedge clk);
    endtask

    task automatic single(input logic [AW-1:0] r, input logic [AW-1:0] c,
                          input logic w, input logic d, input string req);
        addr = c; cas = 1'b1; we = w; din = d; nib = 1'b0;
        @(negedge clk);
        if (w) begin
            check(dout_vld == 1'b0, req, dout_vld, 0);
            mdl[r][c] = d;
        end else begin
            check(dout_vld == 1'b1 && dout == mdl[r][c], req, {dout_vld, dout}, {1'b1, mdl[r][c]});
        end
        cas = 1'b0; we = 1'b0;
        @(negedge clk);
    endtask

    task automatic nib_read(input logic [AW-1:0] r, input logic [AW-1:0] c);
        addr = c; cas = 1'b1; nib = 1'b1; we = 1'b0;
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            cas = 1'b0; nib = 1'b0;
            check(dout_vld == 1'b1 && dout == mdl[r][nib_col(c, b)], "R6 nibble read beat",
                  {dout_vld, dout}, {1'b1, mdl[r][nib_col(c, b)]});
        end
        @(negedge clk);
        check(dout_vld == 1'b0, "R6 burst ends after four beats", dout_vld, 0);
    endtask

    task automatic nib_write(input logic [AW-1:0] r, input logic [AW-1:0] c, input logic [3:0] d);
        addr = c; cas = 1'b1; nib = 1'b1; we = 1'b1; din = d[0];
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            mdl[r][nib_col(c, b)] = d[b];
            check(dout_vld == 1'b0, "R6 nibble write no read data", dout_vld, 0);
            cas = 1'b0; nib = 1'b0; we = 1'b0;
            if (b < 3) din = d[b+1];
        end
    endtask

    initial begin
        do_reset();
        // R1 reset state
        check(dout_vld == 1'b0 && err == 1'b0 && ret_err == 1'b0, "R1 reset outputs",
              {dout_vld, err, ret_err}, 0);
        open_row(4'd0);
        single(4'd0, 4'd0, 1'b0, 1'b0, "R1 cleared cell");
        single(4'd0, 4'd15, 1'b0, 1'b0, "R1 cleared cell");
        close_row();

        // Table: R2 open, R3 read, R4 write, R8 write-back, R6 nibble
        foreach (TBL[i]) begin
            open_row(TBL[i].row);
            case (TBL[i].op)
                OP_W:  single(TBL[i].row, TBL[i].col, 1'b1, TBL[i].data[0], "R4 write");
                OP_R:  single(TBL[i].row, TBL[i].col, 1'b0, 1'b0, "R2 R3 R8 read after reopen");
                OP_NR: nib_read(TBL[i].row, TBL[i].col);
                default: nib_write(TBL[i].row, TBL[i].col, TBL[i].data);
            endcase
            close_row();
        end

        // R5 page mode: several column strobes on one open row
        open_row(4'd5);
        single(4'd5, 4'd1, 1'b1, 1'b1, "R5 page write");
        single(4'd5, 4'd2, 1'b1, 1'b1, "R5 page write");
        single(4'd5, 4'd1, 1'b0, 1'b0, "R5 page read own write");
        single(4'd5, 4'd2, 1'b0, 1'b0, "R5 page read");
        single(4'd5, 4'd0, 1'b0, 1'b0, "R5 page read untouched");
        close_row();
        open_row(4'd1);
        single(4'd1, 4'd1, 1'b0, 1'b0, "R5 other row unaffected");
        close_row();

        // R10 column strobe with no open row: error, no data, no cell change
        addr = 4'd5; we = 1'b1; din = 1'b1; cas = 1'b1;
        @(negedge clk);
        check(err == 1'b1 && dout_vld == 1'b0, "R10 error flag", {err, dout_vld}, 2);
        cas = 1'b0; we = 1'b0; din = 1'b0;
        @(negedge clk);
        check(err == 1'b0, "R10 error one cycle", err, 0);
        open_row(4'd5);
        single(4'd5, 4'd5, 1'b0, 1'b0, "R10 cell not written");
        close_row();

        // R7 strobe edge during a burst is ignored
        open_row(4'd3);
        addr = 4'd6; cas = 1'b1; nib = 1'b1;
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            nib = 1'b0;
            if (b == 0) cas = 1'b0;
            if (b == 1) begin cas = 1'b1; addr = 4'd0; end
            check(dout_vld == 1'b1 && dout == mdl[3][nib_col(4'd6, b)], "R7 beat column kept",
                  {dout_vld, dout}, {1'b1, mdl[3][nib_col(4'd6, b)]});
        end
        @(negedge clk);
        check(dout_vld == 1'b0 && err == 1'b0, "R7 no extra access", {dout_vld, err}, 0);
        close_row();

        // R8 closing the row stops a running burst
        open_row(4'd12);
        addr = 4'd12; cas = 1'b1; nib = 1'b1;
        @(negedge clk);
        cas = 1'b0; nib = 1'b0;
        check(dout_vld == 1'b1, "R8 first beat", dout_vld, 1);
        @(negedge clk);
        check(dout_vld == 1'b1, "R8 second beat", dout_vld, 1);
        ras = 1'b0;
        @(negedge clk);
        check(dout_vld == 1'b0, "R8 burst stopped", dout_vld, 0);
        @(negedge clk);
        check(dout_vld == 1'b0, "R8 burst stays stopped", dout_vld, 0);

        // R9 refresh keeps contents
        open_row(4'd9);
        close_row();
        open_row(4'd9);
        single(4'd9, 4'd0, 1'b0, 1'b0, "R9 refresh keeps bit");
        single(4'd9, 4'd3, 1'b0, 1'b0, "R9 refresh keeps bit");
        single(4'd9, 4'd1, 1'b0, 1'b0, "R9 refresh keeps bit");
        close_row();

        // R11 retention
        do_reset();
        for (int s = 0; s < 25; s++)
            for (int r = 0; r < N; r++) begin
                open_row(AW'(r));
                close_row();
            end
        check(ret_err == 1'b0, "R11 refreshed rows no error", ret_err, 0);
        repeat (LIMIT + 40) @(negedge clk);
        check(ret_err == 1'b1, "R11 idle beyond limit", ret_err, 1);
        repeat (3) @(negedge clk);
        check(ret_err == 1'b1, "R11 flag sticky", ret_err, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule